// File: doc/BRIEF.md
# Effective Address Generator

This unit works out where an instruction's operand lives for a small 8-bit processor with a 16-bit address bus. Each cycle the decode stage gives it an addressing mode, the address of the opcode byte, up to two operand bytes, the two index registers and the stack pointer. It returns the following, all registered one clock later:

- the effective address;
- a flag that marks an immediate operand;
- the instruction length;
- the sequential or branch-taken next program counter;
- the relative branch target;
- the stack address for push and pull accesses.

The unit applies the usual 8-bit machine address rules:

- Indexing inside page zero wraps within that page.
- Two-byte operands are little-endian.
- Relative offsets are signed and counted from the address that follows the branch instruction.

Out of reset the next-PC output holds the start address $0600 and the stack address points at $01FD.

Top module: `eag_unit`

## Requirements
- R1: `ins_len` is 1 for implied (mode code 0) and for the unused codes 9 to 15. It is 2 for immediate (1), zero page (2), zero page plus X (3), zero page plus Y (4) and relative (8). It is 3 for absolute (5), absolute plus X (6) and absolute plus Y (7).
- R2: `is_imm` is 1 only in immediate mode. In that mode `ea` equals `op_addr` + 1, modulo 2^16.
- R3: In zero page mode `ea` is {8'h00, `opnd_lo`}.
- R4: In zero page indexed modes `ea` is {8'h00, (`opnd_lo` + index) mod 256}, where the index is `idx_x` for code 3 and `idx_y` for code 4. The upper byte of `ea` is always zero.
- R5: In absolute mode `ea` is {`opnd_hi`, `opnd_lo`}, so the low byte comes first in memory.
- R6: In absolute indexed modes `ea` is ({`opnd_hi`, `opnd_lo`} + index) mod 2^16, where the index is `idx_x` for code 6 and `idx_y` for code 7.
- R7: `br_target` is (`op_addr` + 2 + sign-extended `opnd_lo`) mod 2^16 in every mode. In relative mode `ea` equals `br_target`. In implied mode and for unused codes `ea` is zero.
- R8: `next_pc` is `br_target` when the mode is relative and `branch_taken` is 1. Otherwise it is (`op_addr` + `ins_len`) mod 2^16. `branch_taken` has no effect outside relative mode.
- R9: `stack_addr` is {8'h01, `sp`}.
- R10: While reset is held and until the first rising edge after its release, the outputs have these values: `next_pc` = 16'h0600, `stack_addr` = 16'h01FD, `ins_len` = 1, and `ea`, `is_imm` and `br_target` all zero.
- R11: Every output reflects the inputs sampled at the preceding rising clock edge, which is one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 4 | Addressing mode code (see R1) |
| op_addr | input | 16 | Address of the opcode byte |
| opnd_lo | input | 8 | First operand byte (low byte, zero page address or branch offset) |
| opnd_hi | input | 8 | Second operand byte (high byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| sp | input | 8 | Stack pointer |
| branch_taken | input | 1 | Branch condition result |
| ea | output | 16 | Effective address |
| is_imm | output | 1 | Operand is immediate |
| ins_len | output | 2 | Instruction length in bytes |
| next_pc | output | 16 | Next program counter |
| br_target | output | 16 | Relative branch target |
| stack_addr | output | 16 | Stack page address |

## Verification
The hardest cases to reach are the wrap boundaries. These are:

- a zero page index sum that passes $FF;
- an absolute indexed sum that passes $FFFF;
- a backward branch whose target falls below $0000;
- an immediate or sequential address taken from an opcode at $FFFE or $FFFF.

Random operands almost never land on these edges. Directed vectors therefore place `op_addr`, the operand bytes and the index registers right on them. Further vectors drive `branch_taken` high in non-relative modes, and a random sweep over all sixteen mode codes covers the rest.

// File: rtl/eag_pkg.sv
package eag_pkg;

   typedef enum logic [3:0] {
      AM_IMPL = 4'd0,
      AM_IMM  = 4'd1,
      AM_ZP   = 4'd2,
      AM_ZPX  = 4'd3,
      AM_ZPY  = 4'd4,
      AM_ABS  = 4'd5,
      AM_ABSX = 4'd6,
      AM_ABSY = 4'd7,
      AM_REL  = 4'd8
   } amode_e;

   localparam int LEN_W = 2;

endpackage

// File: rtl/eag_length.sv
module eag_length
   import eag_pkg::*;
(
   input  logic [3:0]       mode,
   output logic [LEN_W-1:0] len
);

   always_comb begin
      case (mode)
         AM_IMM, AM_ZP, AM_ZPX, AM_ZPY, AM_REL: len = 2'd2;
         AM_ABS, AM_ABSX, AM_ABSY:              len = 2'd3;
         default:                               len = 2'd1;
      endcase
   end

endmodule

// File: rtl/eag_index_add.sv
module eag_index_add #(
   parameter int BASE_W = 8,
   parameter int IDX_W  = 8,
   parameter int OUT_W  = 16
) (
   input  logic [BASE_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   output logic [OUT_W-1:0]  sum
);

   localparam int PAD_W = OUT_W - BASE_W;

   logic [BASE_W-1:0] wrapped;

   if (IDX_W > BASE_W) begin : g_bad_idx
      $error("eag_index_add: index wider than base");
   end
   if (OUT_W < BASE_W) begin : g_bad_out
      $error("eag_index_add: output narrower than base");
   end

   assign wrapped = base + {{(BASE_W-IDX_W){1'b0}}, idx};

   if (PAD_W > 0) begin : g_pad
      assign sum = {{PAD_W{1'b0}}, wrapped};
   end else begin : g_nopad
      assign sum = wrapped;
   end

endmodule

// File: rtl/eag_rel.sv
module eag_rel #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] offset,
   output logic [ADDR_W-1:0] target
);

   localparam int EXT_W = ADDR_W - DATA_W;

   logic [ADDR_W-1:0] after_branch;

   assign after_branch = op_addr + ADDR_W'(2);
   assign target       = after_branch + {{EXT_W{offset[DATA_W-1]}}, offset};

endmodule

// File: rtl/eag_unit.sv
module eag_unit
   import eag_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 8,
   parameter logic [15:0] RESET_PC   = 16'h0600,
   parameter logic [7:0]  RESET_SP   = 8'hFD,
   parameter logic [7:0]  STACK_PAGE = 8'h01,
   parameter bit          REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        mode,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] opnd_lo,
   input  logic [DATA_W-1:0] opnd_hi,
   input  logic [DATA_W-1:0] idx_x,
   input  logic [DATA_W-1:0] idx_y,
   input  logic [DATA_W-1:0] sp,
   input  logic              branch_taken,
   output logic [ADDR_W-1:0] ea,
   output logic              is_imm,
   output logic [LEN_W-1:0]  ins_len,
   output logic [ADDR_W-1:0] next_pc,
   output logic [ADDR_W-1:0] br_target,
   output logic [ADDR_W-1:0] stack_addr
);

   localparam int LEN_PAD = ADDR_W - LEN_W;

   if (ADDR_W != 2 * DATA_W) begin : g_chk_width
      $error("eag_unit: address must be two data bytes wide");
   end
   if (ADDR_W != 16 || DATA_W != 8) begin : g_chk_reset
      $error("eag_unit: reset constants assume a 16-bit bus");
   end

   logic [ADDR_W-1:0] opnd_word;
   logic [DATA_W-1:0] index_sel;
   logic [ADDR_W-1:0] zp_sum;
   logic [ADDR_W-1:0] abs_sum;
   logic [ADDR_W-1:0] rel_tgt;
   logic [LEN_W-1:0]  len_c;
   logic [ADDR_W-1:0] ea_c;
   logic [ADDR_W-1:0] npc_c;
   logic              imm_c;
   logic [ADDR_W-1:0] stk_c;

   assign opnd_word = {opnd_hi, opnd_lo};
   assign index_sel = (mode == AM_ZPY || mode == AM_ABSY) ? idx_y : idx_x;

   eag_length u_len (
      .mode (mode),
      .len  (len_c)
   );

   eag_index_add #(.BASE_W(DATA_W), .IDX_W(DATA_W), .OUT_W(ADDR_W)) u_zp_add (
      .base (opnd_lo),
      .idx  (index_sel),
      .sum  (zp_sum)
   );

   eag_index_add #(.BASE_W(ADDR_W), .IDX_W(DATA_W), .OUT_W(ADDR_W)) u_abs_add (
      .base (opnd_word),
      .idx  (index_sel),
      .sum  (abs_sum)
   );

   eag_rel #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rel (
      .op_addr (op_addr),
      .offset  (opnd_lo),
      .target  (rel_tgt)
   );

   always_comb begin
      case (mode)
         AM_IMM:            ea_c = op_addr + ADDR_W'(1);
         AM_ZP:             ea_c = {{DATA_W{1'b0}}, opnd_lo};
         AM_ZPX, AM_ZPY:    ea_c = zp_sum;
         AM_ABS:            ea_c = opnd_word;
         AM_ABSX, AM_ABSY:  ea_c = abs_sum;
         AM_REL:            ea_c = rel_tgt;
         default:           ea_c = '0;
      endcase
   end

   assign imm_c = (mode == AM_IMM);
   assign npc_c = (mode == AM_REL && branch_taken) ? rel_tgt
                : op_addr + {{LEN_PAD{1'b0}}, len_c};
   assign stk_c = {STACK_PAGE, sp};

   if (REG_OUT) begin : g_reg
      logic primed;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ea         <= '0;
            is_imm     <= 1'b0;
            ins_len    <= LEN_W'(1);
            next_pc    <= RESET_PC;
            br_target  <= '0;
            stack_addr <= {STACK_PAGE, RESET_SP};
            primed     <= 1'b0;
         end else begin
            ea         <= ea_c;
            is_imm     <= imm_c;
            ins_len    <= len_c;
            next_pc    <= npc_c;
            br_target  <= rel_tgt;
            stack_addr <= stk_c;
            primed     <= 1'b1;
         end
      end

      // R1: absolute family reports three bytes
      assert_abs_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
         primed && ($past(mode) inside {AM_ABS, AM_ABSX, AM_ABSY}) |-> ins_len == 2'd3);

      // R2: immediate flag and address follow the opcode
      assert_imm_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(mode) == AM_IMM |-> is_imm && ea == $past(op_addr) + 16'd1);

      // R4: zero page indexing never leaves page zero
      assert_zp_page_R4: assert property (@(posedge clk) disable iff (!rst_n)
         primed && ($past(mode) inside {AM_ZPX, AM_ZPY}) |-> ea[ADDR_W-1:DATA_W] == '0);

      // R5: little-endian absolute operand
      assert_abs_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
         primed && $past(mode) == AM_ABS |-> ea == {$past(opnd_hi), $past(opnd_lo)});

      // R8: untaken or non-branch advances sequentially
      assert_seq_pc_R8: assert property (@(posedge clk) disable iff (!rst_n)
         primed && !($past(mode) == AM_REL && $past(branch_taken))
         |-> next_pc == $past(op_addr) + {{LEN_PAD{1'b0}}, ins_len});

      // R9: stack address sits on the stack page
      assert_stack_R9: assert property (@(posedge clk) disable iff (!rst_n)
         primed |-> stack_addr == {STACK_PAGE, $past(sp)});
   end else begin : g_comb
      assign ea         = ea_c;
      assign is_imm     = imm_c;
      assign ins_len    = len_c;
      assign next_pc    = npc_c;
      assign br_target  = rel_tgt;
      assign stack_addr = stk_c;
   end

endmodule

// File: tb/test_eag_unit.sv
module test_eag_unit;

   localparam time CLK_HALF = 5ns;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  mode;
   logic [15:0] op_addr;
   logic [7:0]  opnd_lo, opnd_hi, idx_x, idx_y, sp;
   logic        branch_taken;
   logic [15:0] ea, next_pc, br_target, stack_addr;
   logic        is_imm;
   logic [1:0]  ins_len;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   int exp_ea, exp_imm, exp_len, exp_npc, exp_tgt, exp_stk;
   string ea_tag;
   bit have_exp = 0;

   always #CLK_HALF clk = ~clk;

   eag_unit i_eag_unit (
      .clk, .rst_n, .mode, .op_addr, .opnd_lo, .opnd_hi, .idx_x, .idx_y,
      .sp, .branch_taken, .ea, .is_imm, .ins_len, .next_pc, .br_target, .stack_addr
   );

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int ref_len(int m);
      if (m >= 5 && m <= 7) return 3;
      if ((m >= 1 && m <= 4) || m == 8) return 2;
      return 1;
   endfunction

   task automatic compare();
      check("R1 ins_len", ins_len, exp_len);
      check("R2 is_imm", is_imm, exp_imm);
      check({ea_tag, " ea"}, ea, exp_ea);
      check("R7 br_target", br_target, exp_tgt);
      check("R8 next_pc", next_pc, exp_npc);
      check("R9 stack_addr", stack_addr, exp_stk);
   endtask

   // R11: expectation from the inputs driven now is compared one edge later
   task automatic apply(int m, int a, int lo, int hi, int x, int y, int s, bit tk);
      int off, idx;
      @(negedge clk);
      if (have_exp) compare();
      mode = 4'(m); op_addr = 16'(a); opnd_lo = 8'(lo); opnd_hi = 8'(hi);
      idx_x = 8'(x); idx_y = 8'(y); sp = 8'(s); branch_taken = tk;
      off = (lo >= 128) ? lo - 256 : lo;
      idx = (m == 4 || m == 7) ? y : x;
      exp_len = ref_len(m);
      exp_imm = (m == 1) ? 1 : 0;
      exp_tgt = (a + 2 + off) & 32'hFFFF;
      exp_stk = 256 + s;
      case (m)
         1: begin exp_ea = (a + 1) & 32'hFFFF; ea_tag = "R2"; end
         2: begin exp_ea = lo; ea_tag = "R3"; end
         3, 4: begin exp_ea = (lo + idx) % 256; ea_tag = "R4"; end
         5: begin exp_ea = hi * 256 + lo; ea_tag = "R5"; end
         6, 7: begin exp_ea = (hi * 256 + lo + idx) % 65536; ea_tag = "R6"; end
         8: begin exp_ea = exp_tgt; ea_tag = "R7"; end
         default: begin exp_ea = 0; ea_tag = "R7"; end
      endcase
      exp_npc = (m == 8 && tk) ? exp_tgt : (a + exp_len) % 65536;
      have_exp = 1;
   endtask

   initial begin
      #(CLK_HALF * 2 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; mode = '0; op_addr = '0; opnd_lo = '0; opnd_hi = '0;
      idx_x = '0; idx_y = '0; sp = '0; branch_taken = 1'b0;
      repeat (3) @(negedge clk);
      // R10: reset values
      check("R10 next_pc", next_pc, 16'h0600);
      check("R10 stack_addr", stack_addr, 16'h01FD);
      check("R10 ins_len", ins_len, 1);
      check("R10 ea", ea, 0);
      check("R10 is_imm", is_imm, 0);
      check("R10 br_target", br_target, 0);
      rst_n = 1'b1;
      #1;
      check("R10 held after release", next_pc, 16'h0600);

      apply(0, 'h0600, 'h12, 'h34, 0, 0, 'hFD, 0);     // R1 implied
      apply(1, 'h0600, 'hA9, 0, 0, 0, 'hFC, 0);        // R2 immediate
      apply(1, 'hFFFF, 0, 0, 0, 0, 'hFB, 0);           // R2 wrap
      apply(2, 'h0610, 'h80, 'h77, 5, 6, 'h00, 1);     // R3, R8 taken ignored
      apply(3, 'h0620, 'hF0, 0, 'h20, 'h01, 'hFF, 0);  // R4 wrap with X
      apply(4, 'h0630, 'hFF, 0, 'h99, 'h01, 'h10, 0);  // R4 wrap with Y
      apply(5, 'h0640, 'h34, 'h12, 0, 0, 'h20, 1);     // R5, R8 taken ignored
      apply(6, 'h0650, 'hF0, 'hFF, 'h20, 0, 'h30, 0);  // R6 wrap with X
      apply(7, 'h0660, 'hFF, 'h02, 0, 'h01, 'h40, 0);  // R6 page cross with Y
      apply(8, 'h0000, 'h80, 0, 0, 0, 'h50, 1);        // R7 backward wrap, taken
      apply(8, 'h0700, 'h10, 0, 0, 0, 'h60, 0);        // R8 not taken
      apply(8, 'hFFFE, 'h05, 0, 0, 0, 'h70, 1);        // R7 forward wrap
      apply(7, 'hFFFE, 0, 0, 0, 0, 'h80, 0);           // R8 sequential wrap
      apply(12, 'h0800, 'h44, 'h55, 1, 2, 'h90, 1);    // R1 unused code
      for (int i = 0; i < 500; i++)
         apply($urandom % 16, $urandom % 65536, $urandom % 256, $urandom % 256,
               $urandom % 256, $urandom % 256, $urandom % 256, 1'($urandom % 2));
      @(negedge clk);
      compare();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule